// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

A binary counter slice (four bits by default) that steps up or down on each rising clock edge. The counter moves only while its active-low enable is asserted, and a direction input picks the way it steps. An active-low load input copies a data word into the counter at once, without waiting for a clock edge, and takes priority over counting. A synchronous active-high reset clears the count.

Two status outputs let slices be chained into a wider counter. The terminal flag goes high when the count sits at the last value in the current direction. The active-low ripple strobe pulses once for each terminal event, during the low phase of the clock. A wider counter is built by gating each upper slice's enable with the slice below it, so that the lower slice's terminal flag acts as the carry or borrow.

Top module: `updn_counter_stage`

## Requirements
- R1: Bit 0 of `q` is the least significant bit. Counting up wraps from all ones to zero, and counting down wraps from zero to all ones.
- R2: While `load_n` is low, `q` takes the value of `data` without waiting for a clock edge and stays there across clock edges, whatever the enable and direction inputs are.
- R3: With `load_n` high and `en_n` high, `q` keeps its value across clock edges.
- R4: With `load_n` high, `en_n` low and `dir` = 0 (up), each rising clock edge adds one to `q`.
- R5: With `load_n` high, `en_n` low and `dir` = 1 (down), each rising clock edge subtracts one from `q`.
- R6: `tc` is 1 exactly when `q` is all ones and `dir` = 0, or when `q` is zero and `dir` = 1. This holds whatever the level of `en_n`.
- R7: `rc_n` is 0 only while `tc` is 1, `en_n` is 0 and `clk` is low. At all other times it is 1.
- R8: With `load_n` high, a rising clock edge with `rst` high clears `q` to zero.
- R9: Two slices form a counter twice as wide when they share clock, load and direction and the upper slice's enable is the lower slice's `en_n` ORed with the inverse of its `tc`. The upper slice then steps exactly when the lower one wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous clear, active high |
| load_n | input | 1 | Asynchronous parallel load, active low |
| en_n | input | 1 | Count enable (carry/borrow in), active low |
| dir | input | 1 | Direction: 0 counts up, 1 counts down |
| data | input | WIDTH | Word copied into the counter during load |
| q | output | WIDTH | Current count, bit 0 least significant |
| tc | output | 1 | Terminal count for the selected direction |
| rc_n | output | 1 | Ripple strobe, active low, clock-low phase only |

## Verification
A load and an enabled count can fall in the same cycle, because the load is asynchronous and can arrive between edges while the enable is asserted and the counter sits at its terminal value. The bench drops `load_n` partway through the low clock phase with the enable active and the count at its terminal value. It reads `q` before the next rising edge to confirm that the load acted at once, then reads it again after the edge to confirm that the load won over the increment. Every load entry in the stimulus table also keeps the enable asserted across the edge, so the same conflict is exercised throughout the two-slice run.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
package updn_pkg;

    // Default slice width
    localparam int unsigned CNT_W_DEF = 4;

    // Step direction; the encoding matches the dir port
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Status pair carried from the detectors to the top
    typedef struct packed {
        logic at_term;
        logic strobe_n;
    } stage_flags_t;

    // Value a slice reaches at its terminal point in a direction
    function automatic logic [63:0] term_value(input dir_e d, input int unsigned w);
        logic [63:0] ones;
        ones = (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        return (d == DIR_UP) ? ones : 64'd0;
    endfunction

endpackage

// File: rtl/updn_step_logic.sv
`timescale 1ns/1ps
module updn_step_logic
    import updn_pkg::*;
#(
    parameter int unsigned WIDTH = CNT_W_DEF
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_n,
    input  dir_e             dir,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        nxt = cur;
        if (!en_n) begin
            unique case (dir)
                DIR_UP:   nxt = cur + ONE;
                DIR_DOWN: nxt = cur - ONE;
                default:  nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/updn_state_reg.sv
`timescale 1ns/1ps
module updn_state_reg
    import updn_pkg::*;
#(
    parameter int unsigned WIDTH = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic [WIDTH-1:0] data,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);
    // Load is asynchronous and wins over both clear and step
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n)
            q <= data;
        else if (rst)
            q <= '0;
        else
            q <= nxt;
    end

    // R2: while load is held, the register tracks the data word at each edge
    p_load_follow_r2: assert property (@(posedge clk) disable iff (rst)
        !load_n |-> (q == data));

    // R8: a clocked clear with load inactive empties the register
    p_clear_r8: assert property (@(posedge clk)
        (rst && load_n) |=> (!load_n || q == '0));
endmodule

// File: rtl/updn_term_detect.sv
`timescale 1ns/1ps
module updn_term_detect
    import updn_pkg::*;
#(
    parameter int unsigned WIDTH = CNT_W_DEF
) (
    input  logic [WIDTH-1:0] q,
    input  dir_e             dir,
    output logic             tc
);
    localparam logic [WIDTH-1:0] TOP_V = WIDTH'(term_value(DIR_UP, WIDTH));
    localparam logic [WIDTH-1:0] BOT_V = WIDTH'(term_value(DIR_DOWN, WIDTH));

    logic hit_top;
    logic hit_bot;

    generate
        if (WIDTH == 1) begin : g_narrow
            assign hit_top = q[0];
            assign hit_bot = ~q[0];
        end else begin : g_wide
            assign hit_top = (q == TOP_V);
            assign hit_bot = (q == BOT_V);
        end
    endgenerate

    assign tc = (dir == DIR_UP) ? hit_top : hit_bot;
endmodule

// File: rtl/updn_ripple.sv
`timescale 1ns/1ps
module updn_ripple (
    input  logic clk,
    input  logic tc,
    input  logic en_n,
    output logic rc_n
);
    // Low only during the clock-low phase of an enabled terminal cycle
    assign rc_n = ~(tc & ~en_n & ~clk);
endmodule

// File: rtl/updn_counter_stage.sv
`timescale 1ns/1ps
module updn_counter_stage
    import updn_pkg::*;
#(
    parameter int unsigned WIDTH = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic             en_n,
    input  logic             dir,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] q,
    output logic             tc,
    output logic             rc_n
);
    typedef logic [WIDTH-1:0] cnt_t;
    localparam cnt_t MAXV = '1;

    dir_e         dir_s;
    cnt_t         nxt_s;
    cnt_t         q_s;
    stage_flags_t flags;

    assign dir_s = dir_e'(dir);

    updn_step_logic #(.WIDTH(WIDTH)) u_step (
        .cur  (q_s),
        .en_n (en_n),
        .dir  (dir_s),
        .nxt  (nxt_s)
    );

    updn_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .load_n (load_n),
        .data   (data),
        .nxt    (nxt_s),
        .q      (q_s)
    );

    updn_term_detect #(.WIDTH(WIDTH)) u_term (
        .q   (q_s),
        .dir (dir_s),
        .tc  (flags.at_term)
    );

    updn_ripple u_rip (
        .clk  (clk),
        .tc   (flags.at_term),
        .en_n (en_n),
        .rc_n (flags.strobe_n)
    );

    assign q    = q_s;
    assign tc   = flags.at_term;
    assign rc_n = flags.strobe_n;

    // R3: disabled counter keeps its value unless a load intervenes
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (load_n && en_n) |=> (!load_n || $stable(q)));

    // R4: enabled upward step
    p_step_up_r4: assert property (@(posedge clk) disable iff (rst)
        (load_n && !en_n && dir == 1'b0) |=> (!load_n || q == cnt_t'($past(q) + 1'b1)));

    // R5: enabled downward step
    p_step_down_r5: assert property (@(posedge clk) disable iff (rst)
        (load_n && !en_n && dir == 1'b1) |=> (!load_n || q == cnt_t'($past(q) - 1'b1)));

    // R1: overflow from the top wraps to zero
    p_wrap_up_r1: assert property (@(posedge clk) disable iff (rst)
        (load_n && !en_n && dir == 1'b0 && q == MAXV) |=> (!load_n || q == '0));

    // R6: a downward terminal flag predicts the underflow to all ones
    p_term_under_r6: assert property (@(posedge clk) disable iff (rst)
        (tc && load_n && !en_n && dir == 1'b1) |=> (!load_n || q == MAXV));

    // R7: strobe is released whenever the clock is high
    p_strobe_idle_r7: assert property (@(negedge clk) disable iff (rst)
        rc_n);

    // R7: strobe is active in the clock-low phase of an enabled terminal cycle
    p_strobe_fire_r7: assert property (@(posedge clk) disable iff (rst)
        (tc && !en_n) |-> !rc_n);
endmodule

// File: tb/updn_counter_stage_tb.sv
`timescale 1ns/1ps
module updn_counter_stage_tb;
    import updn_pkg::*;

    localparam int NVEC = 12;
    // Entry: {op[17:16], data[15:8], repeat[7:0]}; op 0 hold, 1 up, 2 down, 3 load
    localparam logic [17:0] TBL [NVEC] = '{
        {2'd3, 8'hFC, 8'd1},
        {2'd1, 8'h00, 8'd6},
        {2'd0, 8'h00, 8'd3},
        {2'd2, 8'h00, 8'd5},
        {2'd3, 8'h10, 8'd1},
        {2'd2, 8'h00, 8'd2},
        {2'd3, 8'h7E, 8'd1},
        {2'd1, 8'h00, 8'd3},
        {2'd0, 8'h00, 8'd2},
        {2'd3, 8'h00, 8'd1},
        {2'd2, 8'h00, 8'd1},
        {2'd1, 8'h00, 8'd2}
    };

    logic       clk    = 1'b0;
    logic       rst    = 1'b1;
    logic       load_n = 1'b1;
    logic       en_n   = 1'b0;
    logic       dir    = 1'b0;
    logic [7:0] data   = 8'h00;

    logic [3:0] q_lo, q_hi;
    logic       tc_lo, tc_hi, rc_lo, rc_hi;
    logic       en_hi_n;

    int checks = 0;
    int fails  = 0;
    int ref_v  = 0;
    bit done   = 1'b0;

    // R9: upper slice carry/borrow from the lower slice's terminal flag
    assign en_hi_n = en_n | ~tc_lo;

    always #4 clk = ~clk;

    updn_counter_stage #(.WIDTH(4)) u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .en_n(en_n), .dir(dir),
        .data(data[3:0]), .q(q_lo), .tc(tc_lo), .rc_n(rc_lo)
    );

    updn_counter_stage #(.WIDTH(4)) u_hi (
        .clk(clk), .rst(rst), .load_n(load_n), .en_n(en_hi_n), .dir(dir),
        .data(data[7:4]), .q(q_hi), .tc(tc_hi), .rc_n(rc_hi)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_tc(input int v, input logic d);
        return d ? int'((v & 15) == 0) : int'((v & 15) == 15);
    endfunction

    task automatic step(input logic [1:0] op, input logic [7:0] d);
        string tag;
        int    carry;
        @(negedge clk);
        load_n = (op != 2'd3);
        en_n   = (op == 2'd0);
        dir    = (op != 2'd1);
        data   = d;
        if (op == 2'd3) ref_v = d;
        #1;
        chk("R7", "rc_n low phase", rc_lo, int'(!(exp_tc(ref_v, dir) != 0 && !en_n)));
        carry = exp_tc(ref_v, dir);
        @(posedge clk);
        #1;
        case (op)
            2'd0: tag = "R3";
            2'd1: tag = (carry != 0) ? "R1 R4 R9" : "R4";
            2'd2: tag = (carry != 0) ? "R1 R5 R9" : "R5";
            default: tag = "R2";
        endcase
        if (op == 2'd1) ref_v = (ref_v + 1) & 255;
        else if (op == 2'd2) ref_v = (ref_v + 255) & 255;
        chk(tag, "count", int'({q_hi, q_lo}), ref_v);
        chk("R6", "tc", tc_lo, exp_tc(ref_v, dir));
        chk("R7", "rc_n high phase", rc_lo, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R8: reset while enabled holds the count at zero
        repeat (3) @(posedge clk);
        #1;
        chk("R8", "reset count", int'({q_hi, q_lo}), 0);
        chk("R6", "tc at reset", tc_lo, 0);
        @(negedge clk);
        rst = 1'b0;
        ref_v = 0;

        for (int i = 0; i < NVEC; i++) begin
            for (int k = 0; k < int'(TBL[i][7:0]); k++) begin
                step(TBL[i][17:16], TBL[i][15:8]);
            end
        end

        // R8: clear in the middle of a run
        @(negedge clk);
        load_n = 1'b1;
        rst    = 1'b1;
        en_n   = 1'b0;
        dir    = 1'b0;
        @(posedge clk);
        #1;
        chk("R8", "mid-run clear", int'({q_hi, q_lo}), 0);
        @(negedge clk);
        rst   = 1'b0;
        ref_v = 0;

        // R2: load arriving between edges while an enabled terminal count is due
        step(2'd3, 8'h0F);
        @(negedge clk);
        load_n = 1'b1;
        en_n   = 1'b0;
        dir    = 1'b0;
        #2;
        load_n = 1'b0;
        data   = 8'hA5;
        #1;
        chk("R2", "async load before edge", int'({q_hi, q_lo}), 'hA5);
        @(posedge clk);
        #1;
        chk("R2", "load overrides count", int'({q_hi, q_lo}), 'hA5);
        @(negedge clk);
        load_n = 1'b1;
        en_n   = 1'b1;
        ref_v  = 'hA5;

        // R6: terminal flag independent of enable; R7: no strobe while disabled
        step(2'd3, 8'h0F);
        @(negedge clk);
        load_n = 1'b1;
        en_n   = 1'b1;
        dir    = 1'b0;
        #1;
        chk("R6", "tc up, enable off", tc_lo, 1);
        chk("R7", "rc_n with enable off", rc_lo, 1);
        dir = 1'b1;
        #1;
        chk("R6", "tc down at 0xF", tc_lo, 0);
        @(posedge clk);
        #1;
        chk("R3", "hold while disabled", int'({q_hi, q_lo}), 'h0F);
        step(2'd3, 8'h30);
        @(negedge clk);
        load_n = 1'b1;
        en_n   = 1'b1;
        dir    = 1'b1;
        #1;
        chk("R6", "tc down at zero, enable off", tc_lo, 1);
        chk("R7", "rc_n disabled at terminal", rc_lo, 1);

        finish_run();
    end
endmodule